// File: doc/BRIEF.md
# Effective-Address Translator with Segment Registers and Block Bypass

This block maps a 32-bit effective address to one of two results. Four programmable large-region entries are checked first. When one of them covers the address, the block returns a physical address directly, without any paging step. When none covers it, the top address nibble selects one of sixteen segment registers. The 24-bit segment identifier from that register is then joined with the remaining 28 address bits to form a 52-bit virtual address, which a later page-table stage consumes.

The region entries and the segment registers are loaded by supervisor software through a single write port. That port ignores any write that lacks the privilege qualifier. A lookup is a single-cycle request. Its result appears on registered outputs in the following cycle, and a hit flag tells which of the two address outputs carries the answer.

Top module: `ea_xlate`

## Requirements
- R1: A lookup presented with `req_valid` high in one cycle produces `out_valid` high in the next cycle. A cycle without a request produces `out_valid` low in the next cycle, and `out_hit` is never high while `out_valid` is low.
- R2: When no region entry hits, `out_hit` is 0 and `out_pa` is 0. `out_va` equals {segment register selected by `req_ea[31:28]`, `req_ea[27:12]`, `req_ea[11:0]`}, which is 52 bits.
- R3: Region entry k hits when it is valid and `req_ea[31:17]` equals its 15-bit effective base in every bit position that its 11-bit size mask leaves clear. Mask bit j excludes address bit 17+j from the comparison, so an all-zero mask gives a 128 KB region and an all-ones mask gives a 256 MB region.
- R4: On a hit, `out_hit` is 1 and `out_va` is 0. `out_pa[16:0]` equals `req_ea[16:0]`. In `out_pa[31:17]`, each bit comes from the entry's physical base where the mask bit is clear and from the effective address where the mask bit is set.
- R5: When several region entries hit, the entry with the lowest index supplies the result.
- R6: A write with `wr_priv` low changes no segment register and no region entry.
- R7: A privileged write with `wr_blk`=0 loads segment register `wr_idx` with `wr_data[23:0]`. With `wr_blk`=1 it loads region entry `wr_idx` from `wr_data`, laid out as [41] valid, [40:26] effective base, [25:15] size mask and [14:0] physical base. A region write to an index of 4 or more is ignored.
- R8: After reset every region entry is invalid and every segment register is zero. Each lookup therefore misses, with a segment identifier of 0.
- R9: A lookup made in the same cycle as a write uses the contents from before that write. The following lookup uses the new contents.
- R10: An entry whose valid bit is 0 never hits, even when its base matches the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address to translate |
| wr_en | input | 1 | Register write strobe |
| wr_priv | input | 1 | Supervisor qualifier; a write without it is ignored |
| wr_blk | input | 1 | Write target: 0 selects a segment register, 1 selects a region entry |
| wr_idx | input | 4 | Index of the register or entry to write |
| wr_data | input | 42 | Write data (segment id in the low 24 bits, or a packed region entry) |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_hit | output | 1 | 1: `out_pa` holds the result; 0: `out_va` holds the result |
| out_pa | output | 32 | Physical address from a region hit |
| out_va | output | 52 | Virtual address from the segment path |

## Verification
A corrupted region entry shows up on the first lookup that touches its range. It causes a wrong hit flag or wrong upper physical bits one cycle after the request, and bits from the wrong entry give away a broken priority chain. A wrong segment register can only be seen through the top 24 bits of `out_va` on a miss, so the bench runs lookups across several different top nibbles after every load. Privilege gating and same-cycle write ordering can only be observed through the next lookup, so a lookup follows each such write directly.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
   // Target of a register-port write.
   typedef enum logic {
      WT_SEG = 1'b0,
      WT_BLK = 1'b1
   } wr_tgt_e;
endpackage

// File: rtl/xlt_segfile.sv
module xlt_segfile #(
   parameter int NSEG   = 16,
   parameter int VSID_W = 24,
   parameter int IDX_W  = 4,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [VSID_W-1:0] wdata,
   input  logic [SEL_W-1:0]  rsel,
   output logic [VSID_W-1:0] rvsid
);
   logic [VSID_W-1:0] seg_q [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk) begin
         if (!rst_n)
            seg_q[g] <= '0;
         else if (we && widx == IDX_W'(g))
            seg_q[g] <= wdata;
      end
   end

   assign rvsid = seg_q[rsel];
endmodule

// File: rtl/xlt_blkmatch.sv
module xlt_blkmatch #(
   parameter int NBLK   = 4,
   parameter int BASE_W = 15,
   parameter int MASK_W = 11,
   parameter int IDX_W  = 4,
   localparam int DW    = 1 + 2*BASE_W + MASK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DW-1:0]     wdata,
   input  logic [BASE_W-1:0] ea_hi,
   output logic              hit,
   output logic [BASE_W-1:0] pa_hi
);
   logic              vld_q [NBLK];
   logic [BASE_W-1:0] eb_q  [NBLK];
   logic [MASK_W-1:0] msk_q [NBLK];
   logic [BASE_W-1:0] pb_q  [NBLK];
   logic [NBLK-1:0]   hv;
   logic [BASE_W-1:0] pv    [NBLK];

   for (genvar g = 0; g < NBLK; g++) begin : g_ent
      logic [BASE_W-1:0] mfull;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            eb_q[g]  <= '0;
            msk_q[g] <= '0;
            pb_q[g]  <= '0;
         end else if (we && widx == IDX_W'(g)) begin
            vld_q[g] <= wdata[DW-1];
            eb_q[g]  <= wdata[DW-2 -: BASE_W];
            msk_q[g] <= wdata[BASE_W +: MASK_W];
            pb_q[g]  <= wdata[BASE_W-1:0];
         end
      end
      assign mfull = BASE_W'(msk_q[g]);
      assign hv[g] = vld_q[g] && (((ea_hi ^ eb_q[g]) & ~mfull) == '0);
      assign pv[g] = (pb_q[g] & ~mfull) | (ea_hi & mfull);
   end

   // Lowest index wins: scan downward so the last assignment is the lowest hit.
   always_comb begin
      hit   = 1'b0;
      pa_hi = '0;
      for (int k = NBLK - 1; k >= 0; k--) begin
         if (hv[k]) begin
            hit   = 1'b1;
            pa_hi = pv[k];
         end
      end
   end
endmodule

// File: rtl/ea_xlate.sv
module ea_xlate
   import xlt_pkg::*;
#(
   parameter int EA_W   = 32,
   parameter int OFF_W  = 12,
   parameter int SEL_W  = 4,
   parameter int VSID_W = 24,
   parameter int NBLK   = 4,
   parameter int BASE_W = 15,
   parameter int MASK_W = 11,
   parameter int WIDX_W = 4,
   localparam int NSEG  = 1 << SEL_W,
   localparam int TAIL_W = EA_W - SEL_W,
   localparam int LOW_W = EA_W - BASE_W,
   localparam int VA_W  = VSID_W + TAIL_W,
   localparam int BLK_DW = 1 + 2*BASE_W + MASK_W,
   localparam int WD_W  = (BLK_DW > VSID_W) ? BLK_DW : VSID_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [EA_W-1:0]   req_ea,
   input  logic              wr_en,
   input  logic              wr_priv,
   input  logic              wr_blk,
   input  logic [WIDX_W-1:0] wr_idx,
   input  logic [WD_W-1:0]   wr_data,
   output logic              out_valid,
   output logic              out_hit,
   output logic [EA_W-1:0]   out_pa,
   output logic [VA_W-1:0]   out_va
);
   if (MASK_W > BASE_W) begin : g_bad_mask
      $error("size mask wider than region base");
   end
   if (OFF_W + SEL_W >= EA_W) begin : g_bad_split
      $error("no page-index bits left in the address");
   end
   if (WIDX_W < SEL_W || NBLK > (1 << WIDX_W)) begin : g_bad_idx
      $error("write index too narrow");
   end

   wr_tgt_e           tgt;
   logic              seg_we, blk_we;
   logic [VSID_W-1:0] vsid;
   logic              b_hit;
   logic [BASE_W-1:0] b_pa_hi;

   assign tgt    = wr_tgt_e'(wr_blk);
   assign seg_we = wr_en && wr_priv && (tgt == WT_SEG);
   assign blk_we = wr_en && wr_priv && (tgt == WT_BLK);

   xlt_segfile #(
      .NSEG(NSEG), .VSID_W(VSID_W), .IDX_W(WIDX_W), .SEL_W(SEL_W)
   ) u_seg (
      .clk(clk), .rst_n(rst_n), .we(seg_we), .widx(wr_idx),
      .wdata(wr_data[VSID_W-1:0]), .rsel(req_ea[EA_W-1 -: SEL_W]),
      .rvsid(vsid)
   );

   xlt_blkmatch #(
      .NBLK(NBLK), .BASE_W(BASE_W), .MASK_W(MASK_W), .IDX_W(WIDX_W)
   ) u_blk (
      .clk(clk), .rst_n(rst_n), .we(blk_we), .widx(wr_idx),
      .wdata(wr_data[BLK_DW-1:0]), .ea_hi(req_ea[EA_W-1 -: BASE_W]),
      .hit(b_hit), .pa_hi(b_pa_hi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_hit   <= 1'b0;
         out_pa    <= '0;
         out_va    <= '0;
      end else begin
         out_valid <= req_valid;
         out_hit   <= req_valid && b_hit;
         out_pa    <= (req_valid && b_hit) ? {b_pa_hi, req_ea[LOW_W-1:0]} : '0;
         out_va    <= (req_valid && !b_hit) ? {vsid, req_ea[TAIL_W-1:0]} : '0;
      end
   end
endmodule

// File: rtl/ea_xlate_chk.sv
module ea_xlate_chk #(
   parameter int EA_W   = 32,
   parameter int SEL_W  = 4,
   parameter int BASE_W = 15,
   parameter int VA_W   = 52,
   localparam int TAIL_W = EA_W - SEL_W,
   localparam int LOW_W = EA_W - BASE_W
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic [EA_W-1:0] req_ea,
   input logic            out_valid,
   input logic            out_hit,
   input logic [EA_W-1:0] out_pa,
   input logic [VA_W-1:0] out_va
);
   p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !out_valid);
   p_hit_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_valid);
   p_miss_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_hit || out_va[TAIL_W-1:0] == $past(req_ea[TAIL_W-1:0])));
   p_miss_pa_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_hit) |-> out_pa == '0);
   p_hit_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!out_hit || out_pa[LOW_W-1:0] == $past(req_ea[LOW_W-1:0])));
   p_hit_va_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> out_va == '0);
endmodule

bind ea_xlate ea_xlate_chk #(
   .EA_W(EA_W), .SEL_W(SEL_W), .BASE_W(BASE_W), .VA_W(VA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
   .out_valid(out_valid), .out_hit(out_hit), .out_pa(out_pa), .out_va(out_va)
);

// File: tb/sim_ea_xlate.sv
module sim_ea_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic        wr_en = 1'b0, wr_priv = 1'b0, wr_blk = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [41:0] wr_data = '0;
   logic        out_valid, out_hit;
   logic [31:0] out_pa;
   logic [51:0] out_va;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ea_xlate u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
      .wr_en(wr_en), .wr_priv(wr_priv), .wr_blk(wr_blk), .wr_idx(wr_idx),
      .wr_data(wr_data), .out_valid(out_valid), .out_hit(out_hit),
      .out_pa(out_pa), .out_va(out_va)
   );

   // Reference state
   logic [23:0] m_seg [16];
   logic        m_v [4];
   logic [14:0] m_eb [4];
   logic [10:0] m_mk [4];
   logic [14:0] m_pb [4];

   // Scoreboard queues
   logic        q_hit [$];
   logic [31:0] q_pa [$];
   logic [51:0] q_va [$];
   string       q_tag [$];

   function automatic logic [41:0] ent(logic v, logic [14:0] eb, logic [10:0] mk, logic [14:0] pb);
      return {v, eb, mk, pb};
   endfunction

   task automatic predict_push(logic [31:0] ea, string tag);
      logic        h = 1'b0;
      logic [31:0] pa = '0;
      logic [51:0] va = '0;
      for (int k = 0; k < 4; k++) begin
         logic [14:0] mf;
         mf = {4'b0, m_mk[k]};
         if (!h && m_v[k] && (((ea[31:17] ^ m_eb[k]) & ~mf) == 15'd0)) begin
            h  = 1'b1;
            pa = {(m_pb[k] & ~mf) | (ea[31:17] & mf), ea[16:0]};
         end
      end
      if (!h) va = {m_seg[ea[31:28]], ea[27:0]};
      q_hit.push_back(h); q_pa.push_back(pa); q_va.push_back(va); q_tag.push_back(tag);
   endtask

   task automatic model_write(logic priv, logic blk, logic [3:0] idx, logic [41:0] d);
      if (!priv) return;
      if (!blk) m_seg[idx] = d[23:0];
      else if (idx < 4) begin
         m_v[idx] = d[41]; m_eb[idx] = d[40:26]; m_mk[idx] = d[25:15]; m_pb[idx] = d[14:0];
      end
   endtask

   task automatic lookup(logic [31:0] ea, string tag);
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b1; req_ea = ea;
      predict_push(ea, tag);
   endtask

   task automatic wr(logic priv, logic blk, logic [3:0] idx, logic [41:0] d);
      @(negedge clk);
      req_valid = 1'b0;
      wr_en = 1'b1; wr_priv = priv; wr_blk = blk; wr_idx = idx; wr_data = d;
      model_write(priv, blk, idx, d);
   endtask

   // Write and lookup in one cycle: the expectation uses the old contents.
   task automatic wr_look(logic [3:0] idx, logic [23:0] v, logic [31:0] ea, string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_priv = 1'b1; wr_blk = 1'b0; wr_idx = idx; wr_data = {18'd0, v};
      req_valid = 1'b1; req_ea = ea;
      predict_push(ea, tag);
      model_write(1'b1, 1'b0, idx, {18'd0, v});
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_chk++;
         if (q_hit.size() == 0) begin
            n_fail++;
            $display("FAIL R1 unexpected result: out_valid=1 expected=0");
         end else begin
            logic h; logic [31:0] pa; logic [51:0] va; string t;
            h = q_hit.pop_front(); pa = q_pa.pop_front(); va = q_va.pop_front(); t = q_tag.pop_front();
            if (out_hit !== h || out_pa !== pa || out_va !== va) begin
               n_fail++;
               $display("FAIL %s hit/pa/va actual=%0b/%h/%h expected=%0b/%h/%h",
                        t, out_hit, out_pa, out_va, h, pa, va);
            end
         end
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_seg[i] = '0;
      for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_eb[i] = '0; m_mk[i] = '0; m_pb[i] = '0; end
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0 || out_hit !== 1'b0) begin
         n_fail++;
         $display("FAIL R8 reset outputs actual=%0b%0b expected=00", out_valid, out_hit);
      end
      rst_n = 1'b1;

      // R8: empty tables after reset
      lookup(32'hF123_4567, "R8");
      lookup(32'h8001_ABCD, "R8");

      // R7/R2: load all segment registers, sweep top nibbles
      for (int i = 0; i < 16; i++) wr(1'b1, 1'b0, 4'(i), {18'd0, 24'hA00000 + 24'(i * 24'h111)});
      lookup(32'h3ABC_DEF0, "R2");
      lookup(32'hC000_0FFF, "R2");
      lookup(32'h0FFF_F000, "R2");
      lookup(32'h7123_4567, "R2");

      // R6: unprivileged writes ignored
      wr(1'b0, 1'b0, 4'd3, {18'd0, 24'hFFFFFF});
      lookup(32'h3000_1000, "R6");
      wr(1'b0, 1'b1, 4'd0, ent(1'b1, 15'h0800, 11'h7FF, 15'h7FFF));
      lookup(32'h1000_0000, "R6");

      // R3/R4: 128 KB region at 0x8000_0000 in entry 1
      wr(1'b1, 1'b1, 4'd1, ent(1'b1, 15'h4000, 11'h000, 15'h0123));
      lookup(32'h8001_ABCD, "R4");
      lookup(32'h8002_0000, "R3");
      lookup(32'h8000_0000, "R3");

      // R5: 256 MB region in entry 2 overlaps entry 1
      wr(1'b1, 1'b1, 4'd2, ent(1'b1, 15'h4000, 11'h7FF, 15'h7800));
      lookup(32'h8001_ABCD, "R5");
      lookup(32'h8F00_0010, "R4");
      lookup(32'h9000_0000, "R3");

      // R10: invalid entry 0 with a matching base
      wr(1'b1, 1'b1, 4'd0, ent(1'b0, 15'h4000, 11'h000, 15'h5555));
      lookup(32'h8001_0000, "R10");

      // R7: region write to index 5 ignored
      wr(1'b1, 1'b1, 4'd5, ent(1'b1, 15'h0800, 11'h000, 15'h1111));
      lookup(32'h1000_0000, "R7");

      // R5: valid entry 0 now outranks entries 1 and 2
      wr(1'b1, 1'b1, 4'd0, ent(1'b1, 15'h4000, 11'h003, 15'h2000));
      lookup(32'h8001_ABCD, "R5");
      lookup(32'h8006_0000, "R5");
      lookup(32'h8008_0000, "R5");

      // R9: same-cycle write and lookup
      wr_look(4'd7, 24'h5A5A5A, 32'h7000_2345, "R9");
      lookup(32'h7000_2345, "R9");

      // R1: back-to-back stream then idle
      for (int i = 0; i < 6; i++) lookup(32'h1234_5678 + 32'(i) * 32'h2100_0000, "R1");
      idle();
      idle();
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 idle out_valid actual=%0b expected=0", out_valid);
      end
      n_chk++;
      if (q_hit.size() != 0) begin
         n_fail++;
         $display("FAIL R1 missing results actual=%0d expected=0", q_hit.size());
      end
      done = 1'b1;
      report();
      $finish;
   end
endmodule